// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel interface up and down in a fixed order. Two level inputs set the goal: a controller-enable request and a panel-power request. The block drives three rails toward that goal: the controller enable, the panel supply and the backlight. When power goes up, the controller enable rises first. The panel supply follows only after a settle interval, and the backlight comes on one clock after the panel supply. When power goes down, the steps run in reverse. The backlight goes off first and the panel supply next. The controller enable drops only after the same settle interval.

The settle interval is counted in pulses of a reference tick, such as a 1 ms strobe, so one parameter sets its length. The goal is sampled only while the block is idle. A request that changes during a sequence therefore waits until that sequence ends, and then the newest levels are applied. A busy flag marks a sequence in progress, and a one-cycle done strobe marks the clock edge at which the last rail of a sequence changed.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, ctl_en, panel_pwr, backlight_en, busy and done are all 0.
- R2: panel_pwr rises only on an edge at which ctl_en was already 1. panel_pwr is never 1 while ctl_en is 0.
- R3: On power-up, the panel supply rises on the clock edge that samples the SETTLE_TICKS-th tick. Ticks are counted from the edge after the sequence starts, which is when busy rises.
- R4: On a full power-down, panel_pwr falls first. ctl_en falls on the edge that samples the SETTLE_TICKS-th tick after that, counted from the next edge.
- R5: If panel_pwr is already 0 when the enable request drops, ctl_en falls on the first clock edge that sees the drop, with no wait. busy stays 0 and done pulses.
- R6: backlight_en rises one edge after panel_pwr rises. It falls one edge before panel_pwr falls. It is never 1 while panel_pwr is 0.
- R7: The settled outputs are ctl_en = en_req, panel_pwr = en_req AND pwr_req, and backlight_en = en_req AND pwr_req. A power request made while the enable request is 0 has no effect.
- R8: A change of en_req or pwr_req during a sequence does not cut the sequence short. The sequence completes, and the newest levels are then applied by a following sequence.
- R9: busy is 1 from the edge that starts a multi-step sequence to the edge of its last rail change. done is 1 for exactly the cycle after any sequence's last rail change, and done is never 1 while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference tick strobe that counts the settle interval |
| en_req | input | 1 | Controller-enable request level |
| pwr_req | input | 1 | Panel-power request level |
| ctl_en | output | 1 | Controller enable rail |
| panel_pwr | output | 1 | Panel supply rail |
| backlight_en | output | 1 | Backlight enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe after a sequence's last rail change |

## Verification
The hardest case to reach is a request that reverses direction partway through a settle wait. The block must finish the power-up it started and only then run a full power-down, so the stimulus has to drop both requests while the panel-supply wait is still counting ticks. A directed case does this three cycles into a power-up. Random request changes, at random gaps that are often shorter than the settle window, hit further mid-sequence reversals. Throughout the run, a monitor counts the bench's own tick pulses between rail edges, so each wait length is measured exactly.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UP_WAIT,
        S_BL_ON,
        S_PWR_OFF,
        S_DN_WAIT
    } seq_state_t;

    typedef struct packed {
        logic ctl_en;
        logic panel_pwr;
        logic backlight;
    } rails_t;

    function automatic rails_t goal_rails(input logic en, input logic pwr);
        rails_t r;
        r.ctl_en    = en;
        r.panel_pwr = en & pwr;
        r.backlight = en & pwr;
        return r;
    endfunction

endpackage

// File: rtl/lcd_settle_timer.sv
module lcd_settle_timer #(
    parameter int SETTLE_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = (SETTLE_TICKS < 2) ? 1 : $clog2(SETTLE_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && tick && (cnt == LAST);
endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
    import lcd_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_req,
    input  logic   pwr_req,
    input  logic   expired,
    output logic   tmr_clear,
    output logic   tmr_run,
    output rails_t rails,
    output logic   busy,
    output logic   done
);
    seq_state_t state;
    logic       drop_en;
    rails_t     tgt;

    assign tgt       = goal_rails(en_req, pwr_req);
    assign tmr_clear = (state == S_IDLE) || (state == S_PWR_OFF);
    assign tmr_run   = (state == S_UP_WAIT) || (state == S_DN_WAIT);
    assign busy      = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            rails   <= '0;
            done    <= 1'b0;
            drop_en <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (tgt.panel_pwr && !rails.panel_pwr) begin
                        rails.ctl_en <= 1'b1;
                        state        <= S_UP_WAIT;
                    end else if (!tgt.panel_pwr && rails.panel_pwr) begin
                        rails.backlight <= 1'b0;
                        drop_en         <= !tgt.ctl_en;
                        state           <= S_PWR_OFF;
                    end else if (tgt.ctl_en != rails.ctl_en) begin
                        rails.ctl_en <= tgt.ctl_en;
                        done         <= 1'b1;
                    end
                end
                S_UP_WAIT: begin
                    if (expired) begin
                        rails.panel_pwr <= 1'b1;
                        state           <= S_BL_ON;
                    end
                end
                S_BL_ON: begin
                    rails.backlight <= 1'b1;
                    done            <= 1'b1;
                    state           <= S_IDLE;
                end
                S_PWR_OFF: begin
                    rails.panel_pwr <= 1'b0;
                    if (drop_en) begin
                        state <= S_DN_WAIT;
                    end else begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_DN_WAIT: begin
                    if (expired) begin
                        rails.ctl_en <= 1'b0;
                        done         <= 1'b1;
                        state        <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int SETTLE_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic en_req,
    input  logic pwr_req,
    output logic ctl_en,
    output logic panel_pwr,
    output logic backlight_en,
    output logic busy,
    output logic done
);
    logic   tmr_clear;
    logic   tmr_run;
    logic   expired;
    rails_t rails;

    lcd_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .tick    (tick),
        .expired (expired)
    );

    lcd_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_req    (en_req),
        .pwr_req   (pwr_req),
        .expired   (expired),
        .tmr_clear (tmr_clear),
        .tmr_run   (tmr_run),
        .rails     (rails),
        .busy      (busy),
        .done      (done)
    );

    assign ctl_en       = rails.ctl_en;
    assign panel_pwr    = rails.panel_pwr;
    assign backlight_en = rails.backlight;
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk #(
    parameter int SETTLE_TICKS = 20
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic ctl_en,
    input logic panel_pwr,
    input logic backlight_en,
    input logic busy,
    input logic done
);
    localparam int W = $clog2(SETTLE_TICKS + 2);
    localparam logic [W-1:0] SAT = W'(SETTLE_TICKS + 1);

    logic [W-1:0] ticks_seen;
    logic         pwr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_seen <= '0;
            pwr_q      <= 1'b0;
        end else begin
            pwr_q <= panel_pwr;
            if (!busy || (pwr_q != panel_pwr)) begin
                ticks_seen <= (busy && tick) ? W'(1) : '0;
            end else if (tick && ticks_seen != SAT) begin
                ticks_seen <= ticks_seen + 1'b1;
            end
        end
    end

    // R2
    pwr_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        panel_pwr |-> ctl_en);
    // R2
    pwr_rise_after_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(panel_pwr) |-> $past(ctl_en));
    // R3
    up_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(panel_pwr) |-> ticks_seen == W'(SETTLE_TICKS));
    // R4
    dn_order_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_en) |-> !$past(panel_pwr));
    // R4
    dn_settle_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctl_en) && $past(busy)) |-> ticks_seen == W'(SETTLE_TICKS));
    // R6
    bl_needs_pwr_chk: assert property (@(posedge clk) disable iff (rst)
        backlight_en |-> panel_pwr);
    // R6
    bl_rise_late_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(backlight_en) |-> $past(panel_pwr));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R9
    busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .ctl_en       (ctl_en),
    .panel_pwr    (panel_pwr),
    .backlight_en (backlight_en),
    .busy         (busy),
    .done         (done)
);

// File: tb/test_lcd_pwr_seq.sv
module test_lcd_pwr_seq;
    localparam int SETTLE = 4;
    localparam int TDIV   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic en_req = 1'b0;
    logic pwr_req = 1'b0;
    logic ctl_en, panel_pwr, backlight_en, busy, done;

    int compared = 0;
    int mismatched = 0;
    int bc = 0;
    int tdiv_cnt = 0;
    int pwr_rises = 0;
    bit finished = 0;
    logic p_en = 0, p_pwr = 0, p_bl = 0, p_busy = 0;

    always #5 clk = ~clk;

    lcd_pwr_seq #(.SETTLE_TICKS(SETTLE)) i_lcd_pwr_seq (
        .clk(clk), .rst(rst), .tick(tick), .en_req(en_req), .pwr_req(pwr_req),
        .ctl_en(ctl_en), .panel_pwr(panel_pwr), .backlight_en(backlight_en),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] expect_rails(input logic en, input logic pwr);
        return {en, en & pwr, en & pwr};
    endfunction

    // monitor and tick driver share one block: observe first, then drive
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !p_busy) bc = 0;
            else if (!panel_pwr && p_pwr) bc = 0;
            else if (tick && p_busy) bc++;
            if (panel_pwr && !p_pwr) begin
                pwr_rises++;
                chk(p_en, "R2 power rise needs enable", p_en, 1);
                chk(bc == SETTLE, "R3 up settle ticks", bc, SETTLE);
            end
            if (!ctl_en && p_en && p_busy) begin
                chk(!p_pwr, "R4 power off before enable off", p_pwr, 0);
                chk(bc == SETTLE, "R4 down settle ticks", bc, SETTLE);
            end
            if (!ctl_en && p_en && !p_busy)
                chk(!p_pwr, "R5 skip only when power off", p_pwr, 0);
            if (backlight_en && !p_bl)
                chk(p_pwr, "R6 backlight after power", p_pwr, 1);
            if (!panel_pwr && p_pwr)
                chk(!p_bl && !backlight_en, "R6 backlight off first", p_bl, 0);
            if (done)
                chk(!busy, "R9 done while idle", busy, 0);
            if (!busy && p_busy)
                chk(done, "R9 done at sequence end", done, 1);
        end
        p_en = ctl_en; p_pwr = panel_pwr; p_bl = backlight_en; p_busy = busy;
        tdiv_cnt = (tdiv_cnt + 1) % TDIV;
        tick = (tdiv_cnt == 0);
    end

    task automatic settle_and_check(input string tag);
        logic [2:0] e;
        repeat (60) @(negedge clk);
        e = expect_rails(en_req, pwr_req);
        chk({ctl_en, panel_pwr, backlight_en} == e, tag,
            {ctl_en, panel_pwr, backlight_en}, e);
        chk(!busy, {tag, " idle"}, busy, 0);
    endtask

    initial begin
        int rises0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk({ctl_en, panel_pwr, backlight_en, busy, done} == 5'b0, "R1 in reset",
            {ctl_en, panel_pwr, backlight_en, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({ctl_en, panel_pwr, backlight_en, busy, done} == 5'b0, "R1 after reset",
            {ctl_en, panel_pwr, backlight_en, busy, done}, 0);

        // R2 R3 R6 full power-up
        en_req = 1; pwr_req = 1;
        @(negedge clk);
        chk(ctl_en && !panel_pwr && busy, "R2 enable first", {ctl_en, panel_pwr, busy}, 3'b101);
        settle_and_check("R7 on");

        // power off but stay enabled
        pwr_req = 0;
        settle_and_check("R7 enabled only");

        // R5 skip path
        en_req = 0;
        @(negedge clk);
        chk(!ctl_en, "R5 enable drops at once", ctl_en, 0);
        chk(!busy, "R5 busy stays low", busy, 0);
        chk(done, "R5 done pulse", done, 1);

        // R7 power request without enable is ignored
        pwr_req = 1;
        settle_and_check("R7 power without enable ignored");

        // R4 full power-down
        en_req = 1; pwr_req = 1;
        settle_and_check("R7 on again");
        en_req = 0; pwr_req = 0;
        settle_and_check("R4 full off");

        // R8 request reversed during up wait
        rises0 = pwr_rises;
        en_req = 1; pwr_req = 1;
        repeat (3) @(negedge clk);
        en_req = 0; pwr_req = 0;
        settle_and_check("R8 final off after held request");
        chk(pwr_rises == rises0 + 1, "R8 up sequence completed", pwr_rises - rises0, 1);

        // random phase
        for (int i = 0; i < 60; i++) begin
            en_req  = 1'($urandom_range(0, 1));
            pwr_req = 1'($urandom_range(0, 1));
            repeat ($urandom_range(1, 30)) @(negedge clk);
        end
        settle_and_check("R8 random final");
        en_req = 1; pwr_req = 0;
        settle_and_check("R7 random tail");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule